// File: doc/BRIEF.md
# Receive FIFO Fill Interrupt and Flow Control

This block is the status side of a UART receiver. Received bytes arrive one per strobe from the deserializer and are held in a byte queue. The queue runs in one of two capacities, 8 or 256 entries. The host pops them through a read strobe, and the oldest byte is always visible on the read-data output. The block has one interrupt request with two causes. The first is a fill threshold taken from a two-bit code whose meaning depends on the capacity mode. The second is an idle watchdog that fires when bytes have sat unread for 64 receiver bit times.

The same fill count drives automatic hardware flow control. When enabled, the active-low request-to-send output is pulled high if a start bit is seen while the queue is at or above its high-water mark. The mark is 240 entries in the large mode and full in the small mode. The output returns low once the fill drops under that mark. Capacity mode and threshold code take effect only on a configuration write strobe, and that strobe re-evaluates the interrupt against the new setting.

Top module: `rxq_irq_flow`

## Requirements
- R1: After synchronous reset the queue is empty, irq is 0, rtsn is 0 and overrun is 0. The configuration is small mode with code 00.
- R2: Bytes leave in arrival order. rd_data shows the oldest stored byte whenever the queue is not empty. A rd_en while empty is ignored.
- R3: Capacity is 8 when cfg_deep=0 and 256 when cfg_deep=1. A wr_vld on a full queue with no rd_en in the same cycle discards the byte and sets overrun. Overrun stays set until the next accepted read clears it.
- R4: In small mode the threshold code gives these levels: 2'b00 means fill of 1 or more, 2'b01 means 3 or more, 2'b10 means 6 or more, and 2'b11 means 8.
- R5: In large mode the threshold code gives these levels: 2'b00 means fill of 1 or more, 2'b01 means 128 or more, 2'b10 means 192 or more, and 2'b11 means 256.
- R6: cfg_deep and cfg_thr are captured only on a cycle with cfg_wr=1. The interrupt reflects the new setting from the cycle after. Changes on those inputs without cfg_wr have no effect.
- R7: With wdog_en=1 and a non-empty queue, 64 bit_tick cycles with no accepted write or read raise the watchdog cause. Any accepted write or read restarts the count. The cause clears on the next accepted read, or when wdog_en=0.
- R8: With flow_en=1, a start_det cycle in which the fill is at least the high-water mark drives rtsn high from the next cycle. The mark is 240 in large mode and 8 in small mode.
- R9: rtsn returns low the cycle after a cycle in which the fill is below the mark and no qualifying start_det occurs. With flow_en=0, rtsn is low from the next cycle.
- R10: irq is the OR of the fill-threshold cause and the watchdog cause, so an empty queue never requests an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vld | input | 1 | Received-byte strobe |
| wr_data | input | 8 | Received byte |
| start_det | input | 1 | Valid start bit detected pulse |
| bit_tick | input | 1 | One pulse per receiver 1x bit time |
| rd_en | input | 1 | Host read strobe, pops the oldest byte |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_deep | input | 1 | Capacity mode: 0 = 8 entries, 1 = 256 entries |
| cfg_thr | input | 2 | Interrupt threshold code |
| wdog_en | input | 1 | Idle watchdog enable |
| flow_en | input | 1 | Automatic request-to-send control enable |
| rd_data | output | 8 | Oldest stored byte |
| irq | output | 1 | Receive interrupt request |
| rtsn | output | 1 | Active-low request-to-send, high = stop |
| overrun | output | 1 | A byte was discarded because the queue was full |

## Verification
The assertions assume that the capacity mode changes only while the queue is empty. Shrinking to 8 entries with more than 8 stored would break the bound on the fill count, so the stimulus always drains the queue before a cfg_wr that switches mode. They also assume each strobe is a clean single-cycle level sampled on the clock. The bench drives every input a few nanoseconds after the rising edge and holds it for the whole cycle. Start-bit pulses are issued only with flow control enabled or deliberately disabled, so each rise of rtsn has an identifiable cause.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W        = 8;
    localparam int DEEP_DEPTH    = 256;
    localparam int SHALLOW_DEPTH = 8;
    localparam int SHALLOW_LOW   = 3;
    localparam int SHALLOW_HIGH  = 6;
    localparam int DEEP_RTS_MARK = 240;
    localparam int WDOG_LEN      = 64;

    localparam int PTR_W = $clog2(DEEP_DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int WD_W  = $clog2(WDOG_LEN);

    typedef logic [CNT_W-1:0] fill_t;

    typedef enum logic [1:0] {
        LVL_ANY  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_FULL = 2'b11
    } lvl_code_e;

    typedef struct packed {
        logic      deep;
        lvl_code_e code;
    } rxq_cfg_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic drop;
    } rxq_evt_t;

    function automatic fill_t capacity(logic deep);
        return deep ? fill_t'(DEEP_DEPTH) : fill_t'(SHALLOW_DEPTH);
    endfunction

    function automatic fill_t level_of(rxq_cfg_t c);
        fill_t lv;
        case (c.code)
            LVL_ANY:  lv = fill_t'(1);
            LVL_LOW:  lv = c.deep ? fill_t'(DEEP_DEPTH / 2) : fill_t'(SHALLOW_LOW);
            LVL_HIGH: lv = c.deep ? fill_t'((DEEP_DEPTH * 3) / 4) : fill_t'(SHALLOW_HIGH);
            default:  lv = capacity(c.deep);
        endcase
        return lv;
    endfunction

    function automatic fill_t rts_mark(logic deep);
        return deep ? fill_t'(DEEP_RTS_MARK) : fill_t'(SHALLOW_DEPTH);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  fill_t         cap,
    output logic [DW-1:0] rd_data,
    output fill_t         fill,
    output rxq_evt_t      evt,
    output logic          overrun
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] mask;

    assign mask     = AW'(cap - fill_t'(1));
    assign evt.pop  = rd_en && (fill != '0);
    assign evt.push = wr_vld && ((fill < cap) || evt.pop);
    assign evt.drop = wr_vld && !evt.push;
    assign rd_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (evt.push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill    <= '0;
            overrun <= 1'b0;
        end else begin
            if (evt.push) begin
                wr_ptr <= (wr_ptr + 1'b1) & mask;
            end
            if (evt.pop) begin
                rd_ptr <= (rd_ptr + 1'b1) & mask;
            end
            case ({evt.push, evt.pop})
                2'b10:   fill <= fill + fill_t'(1);
                2'b01:   fill <= fill - fill_t'(1);
                default: fill <= fill;
            endcase
            if (evt.drop) begin
                overrun <= 1'b1;
            end else if (evt.pop) begin
                overrun <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxq_wdog.sv
module rxq_wdog
    import rxq_pkg::*;
#(
    parameter int LEN = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     tick,
    input  logic     not_empty,
    input  rxq_evt_t evt,
    output logic     fired
);
    localparam int W = $clog2(LEN);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (evt.pop) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (evt.push || !not_empty) begin
            cnt   <= '0;
        end else if (tick && !fired) begin
            if (cnt == W'(LEN - 1)) begin
                cnt   <= '0;
                fired <= 1'b1;
            end else begin
                cnt   <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxq_rts.sv
module rxq_rts
    import rxq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  start_det,
    input  fill_t fill,
    input  fill_t mark,
    output logic  rts_off
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rts_off <= 1'b0;
        end else if (start_det && (fill >= mark)) begin
            rts_off <= 1'b1;
        end else if (fill < mark) begin
            rts_off <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_irq_flow.sv
module rxq_irq_flow
    import rxq_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = DEEP_DEPTH,
    parameter int WDLEN = WDOG_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_data,
    input  logic          start_det,
    input  logic          bit_tick,
    input  logic          rd_en,
    input  logic          cfg_wr,
    input  logic          cfg_deep,
    input  logic [1:0]    cfg_thr,
    input  logic          wdog_en,
    input  logic          flow_en,
    output logic [DW-1:0] rd_data,
    output logic          irq,
    output logic          rtsn,
    output logic          overrun
);
    rxq_cfg_t cfg_q;
    fill_t    fill_cnt;
    fill_t    cap_now;
    rxq_evt_t evt;
    logic     wd_fired;
    logic     lvl_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{deep: 1'b0, code: LVL_ANY};
        end else if (cfg_wr) begin
            cfg_q <= '{deep: cfg_deep, code: lvl_code_e'(cfg_thr)};
        end
    end

    assign cap_now = capacity(cfg_q.deep);
    assign lvl_hit = (fill_cnt >= level_of(cfg_q));
    assign irq     = lvl_hit || wd_fired;

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_vld  (wr_vld),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .cap     (cap_now),
        .rd_data (rd_data),
        .fill    (fill_cnt),
        .evt     (evt),
        .overrun (overrun)
    );

    rxq_wdog #(.LEN(WDLEN)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .en        (wdog_en),
        .tick      (bit_tick),
        .not_empty (fill_cnt != '0),
        .evt       (evt),
        .fired     (wd_fired)
    );

    rxq_rts u_rts (
        .clk       (clk),
        .rst       (rst),
        .en        (flow_en),
        .start_det (start_det),
        .fill      (fill_cnt),
        .mark      (rts_mark(cfg_q.deep)),
        .rts_off   (rtsn)
    );
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk
    import rxq_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_vld,
    input logic  rd_en,
    input logic  start_det,
    input logic  flow_en,
    input logic  irq,
    input logic  rtsn,
    input logic  overrun,
    input fill_t fill,
    input fill_t cap
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (fill == '0) && !irq && !rtsn && !overrun);

    p_pop_shrinks_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_vld && (fill != '0)) |=> (fill == $past(fill) - fill_t'(1)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= cap);

    p_drop_flags_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && !rd_en && (fill == cap)) |=> (overrun && $stable(fill)));

    p_rts_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rtsn) |-> ($past(start_det) && $past(flow_en)));

    p_rts_off_r9: assert property (@(posedge clk) disable iff (rst)
        !flow_en |=> !rtsn);

    p_empty_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> !irq);
endmodule

bind rxq_irq_flow rxq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_vld    (wr_vld),
    .rd_en     (rd_en),
    .start_det (start_det),
    .flow_en   (flow_en),
    .irq       (irq),
    .rtsn      (rtsn),
    .overrun   (overrun),
    .fill      (fill_cnt),
    .cap       (cap_now)
);

// File: tb/sim_rxq_irq_flow.sv
module sim_rxq_irq_flow;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_vld = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       start_det = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rd_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_deep = 1'b0;
    logic [1:0] cfg_thr = 2'b00;
    logic       wdog_en = 1'b0;
    logic       flow_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    logic       rtsn;
    logic       overrun;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    rxq_irq_flow u0 (
        .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_data(wr_data),
        .start_det(start_det), .bit_tick(bit_tick), .rd_en(rd_en),
        .cfg_wr(cfg_wr), .cfg_deep(cfg_deep), .cfg_thr(cfg_thr),
        .wdog_en(wdog_en), .flow_en(flow_en), .rd_data(rd_data),
        .irq(irq), .rtsn(rtsn), .overrun(overrun)
    );

    // reference model
    byte unsigned q[$];
    bit       m_deep;
    bit [1:0] m_thr;
    bit       m_ovr, m_fired, m_rneg;
    int       m_cnt;

    function automatic int lvl(bit deep, bit [1:0] c);
        if (!deep) return (c == 0) ? 1 : (c == 1) ? 3 : (c == 2) ? 6 : 8;
        return (c == 0) ? 1 : (c == 1) ? 128 : (c == 2) ? 192 : 256;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_deep = 0; m_thr = 0; m_ovr = 0; m_fired = 0; m_rneg = 0; m_cnt = 0;
        end else begin
            int  sz, cap, mark;
            bit  ard, awr;
            sz   = q.size();
            cap  = m_deep ? 256 : 8;
            mark = m_deep ? 240 : 8;
            ard  = rd_en && (sz > 0);
            awr  = wr_vld && ((sz < cap) || ard);
            if (!flow_en) m_rneg = 0;
            else if (start_det && sz >= mark) m_rneg = 1;
            else if (sz < mark) m_rneg = 0;
            if (!wdog_en) begin m_cnt = 0; m_fired = 0; end
            else if (ard) begin m_cnt = 0; m_fired = 0; end
            else if (awr || sz == 0) m_cnt = 0;
            else if (bit_tick && !m_fired) begin
                if (m_cnt == 63) begin m_fired = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            if (wr_vld && !awr) m_ovr = 1;
            else if (ard) m_ovr = 0;
            if (ard) void'(q.pop_front());
            if (awr) q.push_back(wr_data);
            if (cfg_wr) begin m_deep = cfg_deep; m_thr = cfg_thr; end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_irq;
            e_irq = (q.size() >= lvl(m_deep, m_thr)) || m_fired;
            n_chk++;
            if (irq !== e_irq) begin
                n_bad++;
                $display("FAIL %s irq act=%0b exp=%0b", cur_req, irq, e_irq);
            end
            n_chk++;
            if (rtsn !== m_rneg) begin
                n_bad++;
                $display("FAIL %s rtsn act=%0b exp=%0b", cur_req, rtsn, m_rneg);
            end
            n_chk++;
            if (overrun !== m_ovr) begin
                n_bad++;
                $display("FAIL %s overrun act=%0b exp=%0b", cur_req, overrun, m_ovr);
            end
            if (q.size() > 0) begin
                n_chk++;
                if (rd_data !== q[0]) begin
                    n_bad++;
                    $display("FAIL %s rd_data act=%0h exp=%0h", cur_req, rd_data, q[0]);
                end
            end
        end
    end

    task automatic clk1();
        @(posedge clk);
        #3;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int n, int base);
        for (int i = 0; i < n; i++) begin
            wr_vld = 1'b1; wr_data = 8'(base + i);
            clk1();
        end
        wr_vld = 1'b0;
    endtask

    task automatic pop(int n);
        for (int i = 0; i < n; i++) begin
            rd_en = 1'b1;
            clk1();
        end
        rd_en = 1'b0;
    endtask

    task automatic set_cfg(bit deep, bit [1:0] code);
        cfg_deep = deep; cfg_thr = code; cfg_wr = 1'b1;
        clk1();
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        start_det = 1'b1;
        clk1();
        start_det = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired in phase %s act=hung exp=done", cur_req);
        finish_run();
    end

    initial begin
        repeat (3) clk1();
        rst = 1'b0;
        clk1();
        cur_req = "R1";
        chk("R1", "irq", irq, 0);
        chk("R1", "rtsn", rtsn, 0);
        chk("R1", "overrun", overrun, 0);

        cur_req = "R2";
        push(5, 8'h11);
        chk("R2", "head", rd_data, 8'h11);
        pop(2);
        chk("R2", "head after two reads", rd_data, 8'h13);
        pop(3);
        pop(1);
        push(1, 8'hA5);
        chk("R2", "head after empty read", rd_data, 8'hA5);
        pop(1);

        cur_req = "R4";
        set_cfg(0, 2'b01);
        push(2, 8'h20);
        chk("R4", "irq at 2 code01", irq, 0);
        push(1, 8'h22);
        chk("R4", "irq at 3 code01", irq, 1);
        pop(3);
        set_cfg(0, 2'b10);
        push(5, 8'h30);
        chk("R4", "irq at 5 code10", irq, 0);
        push(1, 8'h35);
        chk("R4", "irq at 6 code10", irq, 1);
        pop(6);
        set_cfg(0, 2'b11);
        push(7, 8'h40);
        chk("R4", "irq at 7 code11", irq, 0);
        push(1, 8'h47);
        chk("R4", "irq at 8 code11", irq, 1);

        cur_req = "R3";
        push(1, 8'hEE);
        chk("R3", "overrun on full write", overrun, 1);
        chk("R3", "head kept", rd_data, 8'h40);
        pop(1);
        chk("R3", "overrun cleared by read", overrun, 0);
        pop(7);
        chk("R3", "last byte not the dropped one", irq, 0);

        cur_req = "R6";
        set_cfg(0, 2'b00);
        push(2, 8'h50);
        chk("R6", "irq code00 at 2", irq, 1);
        cfg_thr = 2'b11;
        clk1();
        clk1();
        chk("R6", "irq without cfg_wr", irq, 1);
        set_cfg(0, 2'b11);
        chk("R6", "irq after cfg_wr", irq, 0);
        pop(2);

        cur_req = "R5";
        set_cfg(1, 2'b01);
        push(127, 0);
        chk("R5", "irq at 127 code01", irq, 0);
        push(1, 127);
        chk("R5", "irq at 128 code01", irq, 1);
        set_cfg(1, 2'b10);
        chk("R5", "irq at 128 code10", irq, 0);
        push(64, 128);
        chk("R5", "irq at 192 code10", irq, 1);
        set_cfg(1, 2'b11);
        chk("R5", "irq at 192 code11", irq, 0);
        push(64, 192);
        chk("R5", "irq at 256 code11", irq, 1);
        cur_req = "R3";
        push(1, 8'h77);
        chk("R3", "overrun on 256", overrun, 1);
        chk("R3", "head after deep overrun", rd_data, 0);
        pop(256);
        chk("R3", "deep drained irq", irq, 0);

        cur_req = "R8";
        set_cfg(1, 2'b00);
        flow_en = 1'b1;
        push(239, 0);
        pulse_start();
        chk("R8", "rtsn start at 239", rtsn, 0);
        push(1, 239);
        pulse_start();
        chk("R8", "rtsn start at 240", rtsn, 1);
        push(1, 240);
        chk("R8", "rtsn held at 241", rtsn, 1);
        cur_req = "R9";
        pop(2);
        clk1();
        chk("R9", "rtsn low below 240", rtsn, 0);
        pop(239);
        cur_req = "R8";
        set_cfg(0, 2'b00);
        push(8, 8'h60);
        pulse_start();
        chk("R8", "rtsn small mode full", rtsn, 1);
        cur_req = "R9";
        flow_en = 1'b0;
        clk1();
        chk("R9", "rtsn low with flow off", rtsn, 0);
        pop(8);

        cur_req = "R7";
        set_cfg(0, 2'b11);
        wdog_en = 1'b1;
        bit_tick = 1'b1;
        push(1, 8'h90);
        repeat (63) clk1();
        chk("R7", "no fire at 63 ticks", irq, 0);
        clk1();
        chk("R7", "fire at 64 ticks", irq, 1);
        chk("R10", "irq from watchdog only", irq, 1);
        pop(1);
        chk("R7", "cleared by read", irq, 0);
        push(1, 8'h91);
        repeat (40) clk1();
        push(1, 8'h92);
        repeat (40) clk1();
        chk("R7", "write restarts count", irq, 0);
        repeat (24) clk1();
        chk("R7", "fire after restart", irq, 1);
        pop(1);
        chk("R7", "read clears, byte left", irq, 0);
        pop(1);
        bit_tick = 1'b0;
        wdog_en = 1'b0;
        cur_req = "R10";
        clk1();
        chk("R10", "empty quiet", irq, 0);
        clk1();
        finish_run();
    end
endmodule